// File: doc/BRIEF.md
# Reset Stretcher Controller

This block turns a reset request from a command decoder into one system-wide reset of fixed length. The request may arrive as a single-cycle pulse or as a level that the decoder leaves high. Only a low-to-high transition of the request starts a sequence. The block then drives its system reset output for a set number of clock cycles. By default that number equals one second at the given clock frequency.

When the hold time ends, a request that is still high is ignored. The block arms again only after it has seen the request low. A decoder that leaves its request line stuck high therefore causes exactly one reset, never an endless or repeated one. The sequencer runs on a free-running clock that keeps going while the rest of the system is held in reset. It has a small controller-level reset of its own. A busy flag shows when a sequence is in progress or when the block is waiting for the request to drop.

All pins are plain control and status signals. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `rst_stretch_ctrl`

## Requirements
- R1: While idle, `sys_rst` goes high on the clock cycle after a cycle in which `rst_req` is sampled high and was sampled low on the cycle before.
- R2: Once asserted, `sys_rst` stays high for exactly `HOLD_CYCLES` consecutive cycles and then goes low. `HOLD_CYCLES` defaults to `CLK_HZ`, which is one second.
- R3: A request that is a single-cycle pulse produces exactly one reset sequence, and `busy` is low on the cycle after `sys_rst` drops.
- R4: A request held high produces exactly one reset sequence. After it, `sys_rst` stays low and `busy` stays high for as long as `rst_req` stays high. `busy` goes low on the cycle after `rst_req` is sampled low.
- R5: Any activity on `rst_req` while `sys_rst` is high has no effect on the hold length. If the request is low when the hold ends, the block returns to idle with no further reset.
- R6: `busy` is high while the reset is held and while the block waits for the request to drop. It is low when the block is idle and armed.
- R7: While `ctl_rst_n` is low, `sys_rst` and `busy` are low. The request history is cleared to low, so a request that is already high when `ctl_rst_n` is released counts as a rising edge.
- R8: After the request has returned low and the block is idle, a new rising edge starts another full reset sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock. It keeps running during system reset. |
| ctl_rst_n | input | 1 | Synchronous active-low reset of the controller itself |
| rst_req | input | 1 | Reset request from the command decoder. It may be a pulse or a level. |
| sys_rst | output | 1 | Registered active-high system reset output |
| busy | output | 1 | High whenever the controller is not idle and armed |

## Verification
The checker assumes that `rst_req` is synchronous to `clk` and changes only between rising edges. It also assumes that `HOLD_CYCLES` is at least one, so a sequence always lasts at least one cycle. The bench drives the request only on falling edges and uses a small hold count, so every sequence ends within a few dozen cycles. It samples `sys_rst` and `busy` on falling edges as well. This gives every transition a fixed cycle to be checked at.

// File: rtl/rst_stretch_pkg.sv
package rst_stretch_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_HOLD  = 2'd1,
    ST_DRAIN = 2'd2
  } stretch_state_e;
endpackage

// File: rtl/rise_detect.sv
module rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= sig;
  end

  assign rise = sig & ~hist_q;
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int unsigned HOLD_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int unsigned CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= LOAD_VAL;
    else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/rst_stretch_ctrl.sv
module rst_stretch_ctrl
  import rst_stretch_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned HOLD_CYCLES = CLK_HZ
) (
  input  logic clk,
  input  logic ctl_rst_n,
  input  logic rst_req,
  output logic sys_rst,
  output logic busy
);
  stretch_state_e state_q, state_d;
  logic req_rise, tmr_expired, tmr_load, tmr_run, sys_rst_q;

  rise_detect u_rise (
    .clk  (clk),
    .rst_n(ctl_rst_n),
    .sig  (rst_req),
    .rise (req_rise)
  );

  hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (ctl_rst_n),
    .load   (tmr_load),
    .run    (tmr_run),
    .expired(tmr_expired)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ARMED: if (req_rise)    state_d = ST_HOLD;
      ST_HOLD:  if (tmr_expired) state_d = rst_req ? ST_DRAIN : ST_ARMED;
      ST_DRAIN: if (!rst_req)    state_d = ST_ARMED;
      default:                   state_d = ST_ARMED;
    endcase
  end

  assign tmr_load = (state_q == ST_ARMED) && req_rise;
  assign tmr_run  = (state_q == ST_HOLD);

  always_ff @(posedge clk) begin
    if (!ctl_rst_n) begin
      state_q   <= ST_ARMED;
      sys_rst_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      sys_rst_q <= (state_d == ST_HOLD);
    end
  end

  assign sys_rst = sys_rst_q;
  assign busy    = (state_q != ST_ARMED);
endmodule

// File: rtl/rst_stretch_chk.sv
module rst_stretch_chk #(
  parameter int unsigned HOLD_CYCLES = 100
) (
  input logic clk,
  input logic ctl_rst_n,
  input logic rst_req,
  input logic sys_rst,
  input logic busy
);
  logic [31:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!ctl_rst_n)   hi_cnt <= '0;
    else if (sys_rst) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  // R1
  start_on_edge_chk: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    $rose(sys_rst) |-> ($past(rst_req) && !$past(busy)));

  // R2
  hold_len_chk: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    $fell(sys_rst) |-> (hi_cnt == HOLD_CYCLES));

  // R2
  hold_bound_chk: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    sys_rst |-> (hi_cnt < HOLD_CYCLES));

  // R4
  drain_req_high_chk: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    (busy && !sys_rst) |-> $past(rst_req));

  // R4
  busy_drop_chk: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    $fell(busy) |-> !$past(rst_req));

  // R6
  rst_implies_busy_chk: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    sys_rst |-> busy);

  // R7
  always_comb begin
    if (!ctl_rst_n) begin
      ctl_reset_quiet_chk: assert (!busy || !sys_rst || $time == 0);
    end
  end
endmodule

bind rst_stretch_ctrl rst_stretch_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk      (clk),
  .ctl_rst_n(ctl_rst_n),
  .rst_req  (rst_req),
  .sys_rst  (sys_rst),
  .busy     (busy)
);

// File: tb/rst_stretch_ctrl_tb_top.sv
module rst_stretch_ctrl_tb_top;
  localparam int H = 12;

  logic clk = 1'b0;
  logic ctl_rst_n = 1'b0;
  logic rst_req = 1'b0;
  logic sys_rst, busy;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rst_stretch_ctrl #(.CLK_HZ(100_000_000), .HOLD_CYCLES(H)) dut_i (
    .clk(clk), .ctl_rst_n(ctl_rst_n), .rst_req(rst_req),
    .sys_rst(sys_rst), .busy(busy)
  );

  task automatic chk(string req, bit ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Called at the first falling edge with sys_rst high; returns the high length.
  task automatic count_hold(output int len, input bit toggle);
    len = 1;
    @(negedge clk);
    while (sys_rst && len < 4*H) begin
      len++;
      if (toggle) rst_req = (len < H-2) ? ~rst_req : 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic quiet_window(string req, int cycles);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sys_rst) seen++;
    end
    chk(req, seen == 0, seen, 0);
  endtask

  task automatic t_reset();
    ctl_rst_n = 1'b0; rst_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 sys_rst in ctl reset", sys_rst == 1'b0, sys_rst, 0);
    chk("R7 busy in ctl reset", busy == 1'b0, busy, 0);
    ctl_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 busy idle", busy == 1'b0, busy, 0);
  endtask

  task automatic t_pulse();
    int len;
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    chk("R1 assert after pulse edge", sys_rst == 1'b1, sys_rst, 1);
    chk("R6 busy in hold", busy == 1'b1, busy, 1);
    count_hold(len, 1'b0);
    chk("R2 hold length pulse", len == H, len, H);
    chk("R3 busy low after pulse seq", busy == 1'b0, busy, 0);
    quiet_window("R3 single sequence", 2*H);
  endtask

  task automatic t_level();
    int len, bad;
    rst_req = 1'b1;
    @(negedge clk);
    chk("R1 assert after level edge", sys_rst == 1'b1, sys_rst, 1);
    count_hold(len, 1'b0);
    chk("R2 hold length level", len == H, len, H);
    chk("R4 busy while level high", busy == 1'b1, busy, 1);
    bad = 0;
    for (int i = 0; i < 3*H; i++) begin
      @(negedge clk);
      if (sys_rst || !busy) bad++;
    end
    chk("R4 no retrigger while high", bad == 0, bad, 0);
    rst_req = 1'b0;
    @(negedge clk);
    chk("R4 busy drops after req low", busy == 1'b0, busy, 0);
  endtask

  task automatic t_rearm();
    int len;
    repeat (2) @(negedge clk);
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    chk("R8 rearmed edge asserts", sys_rst == 1'b1, sys_rst, 1);
    count_hold(len, 1'b0);
    chk("R8 rearmed hold length", len == H, len, H);
  endtask

  task automatic t_toggle();
    int len;
    repeat (2) @(negedge clk);
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    chk("R1 assert before toggling", sys_rst == 1'b1, sys_rst, 1);
    count_hold(len, 1'b1);
    chk("R5 hold length with toggling", len == H, len, H);
    chk("R5 idle after toggled hold", busy == 1'b0, busy, 0);
    quiet_window("R5 toggles cause no second reset", 2*H);
  endtask

  task automatic t_req_high_at_reset();
    int len;
    @(negedge clk);
    ctl_rst_n = 1'b0; rst_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 outputs low with req high in reset", !sys_rst && !busy, {sys_rst, busy}, 0);
    ctl_rst_n = 1'b1;
    @(negedge clk);
    chk("R7 req high at release counts as edge", sys_rst == 1'b1, sys_rst, 1);
    count_hold(len, 1'b0);
    chk("R2 hold length after release", len == H, len, H);
    rst_req = 1'b0;
    @(negedge clk);
    chk("R6 busy low once idle", busy == 1'b0, busy, 0);
  endtask

  initial begin
    #(200000 * 10);
    chk("watchdog", 1'b0, 1, 0);
    summary();
  end

  initial begin
    t_reset();
    t_pulse();
    t_level();
    t_rearm();
    t_toggle();
    t_req_high_at_reset();
    summary();
  end
endmodule